// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that runs from a slow 32.768 kHz clock. A prescaler divides that clock down to a 4 Hz tick, and each tick advances a 2-bit tick counter. When the counter reaches the terminal count chosen by a select input, the block drives its reset output high for exactly one clock cycle and starts timing again from zero. The two choices give timeouts of about 250 ms (one tick) and about 750 ms (three ticks).

Software keeps the system alive by writing the watchdog's register address over the serial bus. The bus decoder turns that write into a one-cycle `kick` strobe. A kick clears both the prescaler and the tick counter, so the next timeout is measured from the kick. While the enable input is low, all timing state is held at zero and no reset is produced. An active-low power-on reset clears everything. All pins are plain level or strobe controls. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset (`por_n` low), `wd_rst` is low, and timing starts from a cleared prescaler and counter.
- R2: With `long_sel` = 0 and `wd_en` held high, `wd_rst` rises after exactly PRESCALE_DIV*SHORT_TICKS+1 rising clock edges, counted from the first edge at which `wd_en` is sampled high.
- R3: With `long_sel` = 1, the same count is PRESCALE_DIV*LONG_TICKS+1 edges.
- R4: `wd_rst` is high for exactly one cycle. After each pulse, the prescaler and counter restart from zero, so pulses repeat with the same period while no kick arrives.
- R5: A `kick` sampled at a clock edge clears the prescaler and the counter at that edge. The next pulse comes a full timeout after the kick. A kick in the cycle where the timeout would fire suppresses that pulse.
- R6: While `wd_en` is low, `wd_rst` stays low and the timing state is held at zero. Dropping `wd_en` in the cycle where the timeout would fire suppresses the pulse. Re-enabling restarts a full timeout.
- R7: The timeout fires whenever the count is at or above the selected terminal count. Switching `long_sel` from 1 to 0 while the count is already 2 produces a pulse at the next edge.
- R8: Asserting `por_n` in the middle of a timeout aborts it. After release, a full timeout is needed before the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timing clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| wd_en | input | 1 | Watchdog enable; low holds all timing state at zero |
| long_sel | input | 1 | Timeout select: 1 = long (LONG_TICKS), 0 = short (SHORT_TICKS) |
| kick | input | 1 | One-cycle strobe from a bus write to the watchdog address |
| wd_rst | output | 1 | One-cycle reset pulse on timeout |

## Verification
The bench builds the block with PRESCALE_DIV = 16 and keeps the default tick limits of 1 and 3. One long timeout then takes 49 cycles instead of roughly 24,600. This lets the bench check every edge-exact pulse position and the repeat period, for both timeout lengths, inside a short run. The tick limits and the 2-bit counter stay at their default sizes, so the select switch at count 2 and the terminal-count compare are exercised exactly as they are in the full-size block.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Timeout length picked by the select input
  typedef enum logic {
    TO_SHORT = 1'b0,
    TO_LONG  = 1'b1
  } wdog_len_e;

  // Terminal count for a given selection
  function automatic int unsigned wdog_limit(input wdog_len_e sel,
                                             input int unsigned short_ticks,
                                             input int unsigned long_ticks);
    return (sel == TO_LONG) ? long_ticks : short_ticks;
  endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PRESCALE_DIV = 8192
) (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic             at_last;

  assign at_last = (pre_q == PRE_LAST);
  assign tick    = en && !clr && at_last;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pre_q <= '0;
    end else if (!en || clr || at_last) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R2: a tick is followed by a restarted prescale period
  assert_tick_wraps_R2: assert property (@(posedge clk) disable iff (!por_n)
    tick |=> (pre_q == '0));

  // R5/R6: kick, timeout or disable leaves the prescaler at zero
  assert_clear_holds_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!en || clr) |=> (pre_q == '0));

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             en,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (!en || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

  // R3: each tick advances the count by one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!por_n)
    (tick && en && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R6: a disabled watchdog keeps its count at zero
  assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W       = 2,
  parameter int unsigned SHORT_TICKS = 1,
  parameter int unsigned LONG_TICKS  = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             en,
  input  logic             long_sel,
  input  logic             kick,
  input  logic [CNT_W-1:0] cnt,
  output logic             fire,
  output logic             wd_rst
);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_TICKS);

  wdog_len_e        len_sel;
  logic [CNT_W-1:0] limit;
  logic             wd_rst_q;

  assign len_sel = wdog_len_e'(long_sel);
  assign limit   = CNT_W'(wdog_limit(len_sel, SHORT_LIM, LONG_LIM));
  // At-or-above compare so a late switch to the short limit still fires
  assign fire    = en && !kick && (cnt >= limit);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wd_rst_q <= 1'b0;
    end else begin
      wd_rst_q <= fire;
    end
  end

  assign wd_rst = wd_rst_q;

  // R4: the reset output never lasts two cycles
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!por_n)
    wd_rst_q |=> !wd_rst_q);

  // R5: a kick suppresses the pulse in the next cycle
  assert_kick_blocks_R5: assert property (@(posedge clk) disable iff (!por_n)
    kick |=> !wd_rst_q);

  // R6: no pulse follows a disabled cycle
  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!por_n)
    !en |=> !wd_rst_q);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned PRESCALE_DIV = 8192,
  parameter int unsigned CNT_W        = 2,
  parameter int unsigned SHORT_TICKS  = 1,
  parameter int unsigned LONG_TICKS   = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic wd_en,
  input  logic long_sel,
  input  logic kick,
  output logic wd_rst
);
  logic             tick;
  logic             fire;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  // A kick or a timeout restarts the whole timing chain
  assign clr = kick || fire;

  wdog_prescaler #(
    .PRESCALE_DIV(PRESCALE_DIV)
  ) u_prescaler (
    .clk  (clk),
    .por_n(por_n),
    .en   (wd_en),
    .clr  (clr),
    .tick (tick)
  );

  wdog_tick_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk  (clk),
    .por_n(por_n),
    .en   (wd_en),
    .clr  (clr),
    .tick (tick),
    .cnt  (cnt)
  );

  wdog_timeout #(
    .CNT_W      (CNT_W),
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_timeout (
    .clk     (clk),
    .por_n   (por_n),
    .en      (wd_en),
    .long_sel(long_sel),
    .kick    (kick),
    .cnt     (cnt),
    .fire    (fire),
    .wd_rst  (wd_rst)
  );

  // R1: reset output is low in the first cycle after power-on release
  assert_por_quiet_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_n) |-> !wd_rst);

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 16;
  localparam int SHORT_T    = DIV * 1 + 1;
  localparam int LONG_T     = DIV * 3 + 1;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic wd_en = 1'b0;
  logic long_sel = 1'b0;
  logic kick = 1'b0;
  logic wd_rst;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(
    .PRESCALE_DIV(DIV)
  ) u_wdog_timer (
    .clk     (clk),
    .por_n   (por_n),
    .wd_en   (wd_en),
    .long_sel(long_sel),
    .kick    (kick),
    .wd_rst  (wd_rst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // n-1 quiet edges, then a pulse at edge n
  task automatic expect_pulse(input int n, input string req);
    int early = 0;
    for (int i = 1; i < n; i++) begin
      step();
      if (wd_rst) early++;
    end
    check(early == 0, req, "early pulses", early, 0);
    step();
    check(wd_rst == 1'b1, req, "pulse at edge", int'(wd_rst), 1);
  endtask

  task automatic expect_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (wd_rst) seen++;
    end
    check(seen == 0, req, "pulses while quiet", seen, 0);
  endtask

  task automatic kick_once(input string req);
    kick = 1'b1;
    step();
    kick = 1'b0;
    check(wd_rst == 1'b0, req, "no pulse after kick", int'(wd_rst), 0);
  endtask

  task automatic park();
    wd_en = 1'b0;
    step();
    step();
  endtask

  task automatic t_reset();
    #1;
    check(wd_rst == 1'b0, "R1", "reset level", int'(wd_rst), 0);
    step();
    por_n = 1'b1;
    step();
    check(wd_rst == 1'b0, "R1", "after release", int'(wd_rst), 0);
  endtask

  task automatic t_short();
    long_sel = 1'b0;
    wd_en = 1'b1;
    expect_pulse(SHORT_T, "R2");
    expect_pulse(SHORT_T, "R4");
    expect_pulse(SHORT_T, "R4");
    park();
  endtask

  task automatic t_long();
    long_sel = 1'b1;
    wd_en = 1'b1;
    expect_pulse(LONG_T, "R3");
    expect_pulse(LONG_T, "R4");
    park();
  endtask

  task automatic t_kick_mid();
    long_sel = 1'b1;
    wd_en = 1'b1;
    expect_quiet(2 * DIV, "R5");
    kick_once("R5");
    expect_pulse(LONG_T, "R5");
    park();
  endtask

  task automatic t_kick_collide();
    long_sel = 1'b0;
    wd_en = 1'b1;
    expect_quiet(DIV, "R5");
    kick_once("R5");
    expect_pulse(SHORT_T, "R5");
    park();
  endtask

  task automatic t_disable();
    long_sel = 1'b0;
    wd_en = 1'b1;
    expect_quiet(DIV, "R6");
    wd_en = 1'b0;
    expect_quiet(3 * DIV + 2, "R6");
    wd_en = 1'b1;
    expect_pulse(SHORT_T, "R6");
    park();
  endtask

  task automatic t_sel_switch();
    long_sel = 1'b1;
    wd_en = 1'b1;
    expect_quiet(2 * DIV, "R7");
    long_sel = 1'b0;
    expect_pulse(1, "R7");
    park();
  endtask

  task automatic t_por_mid();
    long_sel = 1'b1;
    wd_en = 1'b1;
    expect_quiet(2 * DIV, "R8");
    por_n = 1'b0;
    #1;
    check(wd_rst == 1'b0, "R8", "reset level", int'(wd_rst), 0);
    step();
    step();
    por_n = 1'b1;
    expect_pulse(LONG_T, "R8");
    park();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_kick_mid();
    t_kick_collide();
    t_disable();
    t_sel_switch();
    t_por_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule